// File: doc/BRIEF.md
# Double-Buffered PWM Reload Scheduler

This block is a single-channel PWM time base whose modulus and duty values are written into buffer registers and only become active at a scheduled reload event. The counter runs either edge-aligned (up from zero to the modulus, then back to zero) or center-aligned (up to the modulus, then down to zero). A reload opportunity occurs at the start of every cycle and, optionally, at the peak of a center-aligned cycle. A programmable divider passes one in every 1 to 16 opportunities through as a reload event.

At a reload event the buffered values are copied to the active registers only if the selected load-OK flag is set. That flag is either a local bit written through the register port or a shared global input, so that several time bases can commit new values together. The counter value, a one-cycle reload pulse and a compare output are available at the ports.

Registers are written through a port with a 2-bit address. Address 0 is control: bit 0 selects center-aligned mode, bit 1 enables half-cycle opportunities, bit 2 selects the global load-OK, and bits 6:3 hold the reload divider F. Address 1 is the modulus buffer. Address 2 is the duty buffer. Address 3 bit 0 writes the local load-OK bit.

Top module: `pwm_reload_sched`

## Requirements
- R1: After a synchronous reset, the count is 0, the compare output is low, the reload pulse is low, the active duty is 0 and the active modulus is the parameter RST_MOD.
- R2: In edge-aligned mode the count goes up by one per clock until it equals the active modulus, then returns to 0. The period is modulus+1 clocks.
- R3: In center-aligned mode the count rises from 0 to the modulus and falls back to 0. The period is 2×modulus clocks.
- R4: A cycle-start opportunity occurs at the edge where the count returns to 0. With the half bit set in center-aligned mode, a second opportunity occurs at the peak. In edge-aligned mode the half bit does not change the opportunity rate.
- R5: With divider field F, one reload event occurs every F+1 opportunities. The divider advances on every opportunity whether or not any load-OK is set. Each event produces reload_o high for exactly the one clock after the event edge.
- R6: The active modulus and duty change only at a reload event at which the selected load-OK is set. A buffer write alone leaves the outputs unaffected.
- R7: The local load-OK bit clears itself at the transfer it enables. A later buffer write without a new load-OK is not transferred.
- R8: With control bit 2 set, the global load-OK input replaces the local bit in the transfer decision.
- R9: When a transfer happens at a half-cycle opportunity, the count on the next clock is the new modulus minus one, and counting continues downward.
- R10: The compare output is high exactly when the count is below the active duty, or when the active duty is at least the active modulus. A duty of 0 gives a constant low.
- R11: Writes to the mode, half-cycle and divider fields act from the next clock without waiting for a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 modulus, 2 duty, 3 load-OK) |
| wr_data | input | CNT_W | Write data |
| glob_ldok | input | 1 | Shared global load-OK |
| count_o | output | CNT_W | Current counter value |
| reload_o | output | 1 | One-clock pulse after each reload event |
| pwm_o | output | 1 | Compare output |

## Verification
A corrupted divider state appears as reload pulses at the wrong spacing. The first wrong pulse shows up within one divided period, at most 16 opportunities. A wrong direction flag or count shows on count_o in the very next clock, and it also changes the number of compare-high cycles counted over a PWM period. A load-OK flag stuck high or low lets a duty value through, or holds it back, at the next reload event. That error is seen both as an immediate mismatch against the cycle model and as a changed high-cycle count in the following window.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;
  localparam int PRS_DIV_W = 4;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MOD  = 2'd1;
  localparam logic [1:0] ADDR_DUTY = 2'd2;
  localparam logic [1:0] ADDR_LDOK = 2'd3;

  typedef struct packed {
    logic [PRS_DIV_W-1:0] freq;
    logic                 gsel;
    logic                 half;
    logic                 center;
  } prs_ctrl_t;

  localparam int CTRL_W = $bits(prs_ctrl_t);
endpackage

// File: rtl/prs_regs.sv
module prs_regs
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int RST_MOD = 99
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ldok_clr,
  output prs_ctrl_t        ctrl_q,
  output logic [CNT_W-1:0] mod_buf,
  output logic [CNT_W-1:0] duty_buf,
  output logic             ldok_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      mod_buf  <= CNT_W'(RST_MOD);
      duty_buf <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: ctrl_q   <= prs_ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_MOD:  mod_buf  <= wr_data;
        ADDR_DUTY: duty_buf <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                ldok_q <= 1'b0;
    else if (wr_en && wr_addr == ADDR_LDOK) ldok_q <= wr_data[0];
    else if (ldok_clr)                      ldok_q <= 1'b0;
  end
endmodule

// File: rtl/prs_timebase.sv
module prs_timebase #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             center,
  input  logic             half,
  input  logic [CNT_W-1:0] mod_act,
  input  logic [CNT_W-1:0] mod_nxt,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             opp
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic dn_q, dn_nxt;
  logic at_top, opp_start, opp_half;

  assign at_top    = (cnt_q >= mod_act);
  assign opp_start = center ? (dn_q && cnt_q == '0) : at_top;
  assign opp_half  = center && half && !dn_q && at_top;
  assign opp       = opp_start || opp_half;

  always_comb begin
    cnt_nxt = cnt_q + ONE;
    dn_nxt  = 1'b0;
    if (!center) begin
      if (at_top) cnt_nxt = '0;
    end else if (!dn_q) begin
      if (at_top) begin
        cnt_nxt = mod_nxt - ONE;
        dn_nxt  = 1'b1;
      end
    end else if (cnt_q == '0) begin
      cnt_nxt = ONE;
    end else begin
      cnt_nxt = cnt_q - ONE;
      dn_nxt  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      dn_q  <= dn_nxt;
    end
  end
endmodule

// File: rtl/prs_loader.sv
module prs_loader
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int RST_MOD = 99
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 opp,
  input  logic [PRS_DIV_W-1:0] freq,
  input  logic                 ldok_sel,
  input  logic [CNT_W-1:0]     mod_buf,
  input  logic [CNT_W-1:0]     duty_buf,
  output logic [CNT_W-1:0]     mod_act,
  output logic [CNT_W-1:0]     duty_act,
  output logic [CNT_W-1:0]     mod_nxt,
  output logic [CNT_W-1:0]     duty_nxt,
  output logic                 xfer,
  output logic                 reload_q
);
  logic [PRS_DIV_W-1:0] div_q;
  logic                 expire;

  assign expire   = opp && (div_q >= freq);
  assign xfer     = expire && ldok_sel;
  assign mod_nxt  = xfer ? mod_buf  : mod_act;
  assign duty_nxt = xfer ? duty_buf : duty_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      reload_q <= 1'b0;
      mod_act  <= CNT_W'(RST_MOD);
      duty_act <= '0;
    end else begin
      reload_q <= expire;
      mod_act  <= mod_nxt;
      duty_act <= duty_nxt;
      if (opp) div_q <= expire ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/prs_compare.sv
module prs_compare #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] mod_nxt,
  input  logic [CNT_W-1:0] duty_nxt,
  output logic             pwm_q
);
  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= (duty_nxt >= mod_nxt) || (cnt_nxt < duty_nxt);
  end
endmodule

// File: rtl/pwm_reload_sched.sv
module pwm_reload_sched
  import pwm_reload_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int RST_MOD = 99
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             glob_ldok,
  output logic [CNT_W-1:0] count_o,
  output logic             reload_o,
  output logic             pwm_o
);
  prs_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] mod_buf, duty_buf, mod_act, duty_act, mod_nxt, duty_nxt, cnt_nxt;
  logic             ldok_loc, ldok_sel, ldok_clr, opp, xfer, mode_ctr, gsel, ldok_wr;

  assign mode_ctr = ctrl_q.center;
  assign gsel     = ctrl_q.gsel;
  assign ldok_sel = gsel ? glob_ldok : ldok_loc;
  assign ldok_clr = xfer && !gsel;
  assign ldok_wr  = wr_en && (wr_addr == ADDR_LDOK);

  prs_regs #(.CNT_W(CNT_W), .RST_MOD(RST_MOD)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ldok_clr(ldok_clr), .ctrl_q(ctrl_q), .mod_buf(mod_buf), .duty_buf(duty_buf),
    .ldok_q(ldok_loc)
  );

  prs_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .center(ctrl_q.center), .half(ctrl_q.half),
    .mod_act(mod_act), .mod_nxt(mod_nxt), .cnt_q(count_o), .cnt_nxt(cnt_nxt), .opp(opp)
  );

  prs_loader #(.CNT_W(CNT_W), .RST_MOD(RST_MOD)) u_ld (
    .clk(clk), .rst(rst), .opp(opp), .freq(ctrl_q.freq), .ldok_sel(ldok_sel),
    .mod_buf(mod_buf), .duty_buf(duty_buf), .mod_act(mod_act), .duty_act(duty_act),
    .mod_nxt(mod_nxt), .duty_nxt(duty_nxt), .xfer(xfer), .reload_q(reload_o)
  );

  prs_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .mod_nxt(mod_nxt), .duty_nxt(duty_nxt),
    .pwm_q(pwm_o)
  );
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count_o,
  input logic             pwm_o,
  input logic             reload_o,
  input logic             mode_ctr,
  input logic [CNT_W-1:0] mod_act,
  input logic [CNT_W-1:0] duty_act,
  input logic             xfer,
  input logic             gsel,
  input logic             ldok_loc,
  input logic             ldok_wr
);
  AST_EDGE_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(!mode_ctr) && count_o != '0) |-> count_o == $past(count_o) + CNT_W'(1)); // R2

  AST_ACTIVE_ONLY_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (mod_act != $past(mod_act) || duty_act != $past(duty_act)) |-> reload_o); // R6

  AST_LDOK_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (xfer && !gsel && !ldok_wr) |=> !ldok_loc); // R7

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (rst)
    (duty_act == '0 && mod_act != '0) |-> !pwm_o); // R10

  AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (duty_act >= mod_act) |-> pwm_o); // R10
endmodule

bind pwm_reload_sched prs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .count_o(count_o), .pwm_o(pwm_o), .reload_o(reload_o),
  .mode_ctr(mode_ctr), .mod_act(mod_act), .duty_act(duty_act), .xfer(xfer),
  .gsel(gsel), .ldok_loc(ldok_loc), .ldok_wr(ldok_wr)
);

// File: tb/pwm_reload_sched_test.sv
module pwm_reload_sched_test;
  localparam int W = 15;
  localparam int RMOD = 99;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, glob = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count_o;
  logic         reload_o, pwm_o;
  int checks = 0, fails = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  pwm_reload_sched #(.CNT_W(W), .RST_MOD(RMOD)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .glob_ldok(glob), .count_o(count_o), .reload_o(reload_o), .pwm_o(pwm_o)
  );

  // reference model: pushes expected {count, pwm, reload} each clock
  logic [W+1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] m_cnt, m_mod, m_duty, m_bmod, m_bduty, nm, nd, nc;
  logic         m_dn, m_ctr, m_half, m_gsel, m_ldok, ndn, os, oh, op, ex, lk, xf, npwm;
  logic [3:0]   m_freq, m_div;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_dn = 0; m_mod = W'(RMOD); m_duty = '0; m_bmod = W'(RMOD); m_bduty = '0;
      m_ctr = 0; m_half = 0; m_gsel = 0; m_freq = '0; m_ldok = 0; m_div = '0;
      exp_q.delete(); tag_q.delete();
    end else begin
      os = m_ctr ? (m_dn && m_cnt == '0) : (m_cnt >= m_mod);
      oh = m_ctr && m_half && !m_dn && (m_cnt >= m_mod);
      op = os || oh;
      ex = op && (m_div >= m_freq);
      lk = m_gsel ? glob : m_ldok;
      xf = ex && lk;
      nm = xf ? m_bmod : m_mod;
      nd = xf ? m_bduty : m_duty;
      if (!m_ctr) begin nc = (m_cnt >= m_mod) ? '0 : m_cnt + 1'b1; ndn = 0; end
      else if (!m_dn) begin
        if (m_cnt >= m_mod) begin nc = nm - 1'b1; ndn = 1; end
        else begin nc = m_cnt + 1'b1; ndn = 0; end
      end else if (m_cnt == '0) begin nc = W'(1); ndn = 0; end
      else begin nc = m_cnt - 1'b1; ndn = 1; end
      if (op) m_div = ex ? 4'd0 : m_div + 4'd1;
      if (wr_en && wr_addr == 2'd3) m_ldok = wr_data[0];
      else if (xf && !m_gsel) m_ldok = 0;
      if (wr_en && wr_addr == 2'd0) begin
        m_ctr = wr_data[0]; m_half = wr_data[1]; m_gsel = wr_data[2]; m_freq = wr_data[6:3];
      end
      if (wr_en && wr_addr == 2'd1) m_bmod = wr_data;
      if (wr_en && wr_addr == 2'd2) m_bduty = wr_data;
      m_cnt = nc; m_dn = ndn; m_mod = nm; m_duty = nd;
      npwm = (nd >= nm) || (nc < nd);
      exp_q.push_back({nc, npwm, ex});
      tag_q.push_back(tag);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      logic [W+1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks += 1;
      if ({count_o, pwm_o, reload_o} !== e) begin
        fails += 1;
        $display("FAIL %s: cnt/pwm/rel actual %0d/%0b/%0b expected %0d/%0b/%0b",
                 t, count_o, pwm_o, reload_o, e[W+1:2], e[1], e[0]);
      end
    end
  end

  task automatic chk(input string r, input int act, input int expv);
    checks += 1;
    if (act != expv) begin
      fails += 1;
      $display("FAIL %s: actual %0d expected %0d", r, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int n, output int hi, output int rel);
    hi = 0; rel = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(pwm_o);
      rel += int'(reload_o);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails += 1;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hi, rel, prev;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state (count 0, low outputs)
    chk("R1", int'(count_o), 0);
    chk("R1", int'(pwm_o), 0);
    chk("R1", int'(reload_o), 0);

    // R2/R10 edge-aligned, modulus 9, duty 4
    tag = "R2";
    wr(2'd1, 9); wr(2'd2, 4); wr(2'd3, 1);
    idle(120);
    measure(100, hi, rel);
    chk("R2", rel, 10);
    chk("R10", hi, 40);

    // R5/R6 divider F=2 without load-OK, duty buffered only
    tag = "R5";
    wr(2'd0, 2 << 3); wr(2'd2, 7);
    idle(40);
    measure(300, hi, rel);
    chk("R5", rel, 10);
    chk("R6", hi, 120);

    // R8 global load-OK replaces local
    tag = "R8";
    wr(2'd0, 4); wr(2'd2, 2); wr(2'd3, 1);
    idle(20);
    measure(100, hi, rel);
    chk("R8", hi, 40);
    glob = 1'b1; idle(20); glob = 1'b0;
    measure(100, hi, rel);
    chk("R8", hi, 20);

    // R7 local load-OK self clears
    tag = "R7";
    wr(2'd0, 0); idle(20);
    wr(2'd2, 6); wr(2'd3, 1); idle(20);
    wr(2'd2, 8); idle(20);
    measure(100, hi, rel);
    chk("R7", hi, 60);

    // R10 duty extremes
    tag = "R10";
    wr(2'd2, 0); wr(2'd3, 1); idle(20);
    measure(100, hi, rel);
    chk("R10", hi, 0);
    wr(2'd2, 9); wr(2'd3, 1); idle(20);
    measure(100, hi, rel);
    chk("R10", hi, 100);

    // R4 half bit ignored in edge mode
    tag = "R4";
    wr(2'd0, 2); idle(20);
    measure(100, hi, rel);
    chk("R4", rel, 10);

    // R3/R11 center-aligned, duty 3
    tag = "R3";
    wr(2'd2, 3); wr(2'd3, 1); wr(2'd0, 1); idle(40);
    measure(180, hi, rel);
    chk("R3", rel, 10);
    chk("R3", hi, 50);

    // R4/R11 half-cycle opportunities doubled
    tag = "R11";
    wr(2'd0, 3); idle(20);
    measure(180, hi, rel);
    chk("R11", rel, 20);

    // R9 transfer at peak forces new modulus minus one
    tag = "R9";
    wr(2'd1, 3); idle(5);
    prev = int'(count_o);
    do begin
      @(negedge clk);
      if (int'(count_o) == 8 && prev == 7) break;
      prev = int'(count_o);
    end while (1);
    wr(2'd3, 1);
    @(negedge clk);
    chk("R9", int'(count_o), 2);
    chk("R9", int'(reload_o), 1);
    idle(20);
    finish_run();
  end
endmodule